// File: doc/BRIEF.md
# Windowed Link Utilization Classifier

This block watches a set of links over a fixed measurement window. For every link it counts two things: the cycles in which the link carried a flit, and the cycles in which that link's input buffer was flagged as highly occupied. When the window closes, each link is placed in one of four utilization classes. The class is a 2-bit code that a bandwidth-sharing controller can act on. The codes that are published always describe the window that has just finished. They stay constant while the next window is being measured.

A controller starts measurement by raising `run`. Windows then follow one another as long as `run` stays high. Each window is `win_len` collect cycles followed by one publish cycle, and the publish cycle is not counted. Both thresholds are given in cycles, so software scales them to the window length and the hardware needs no divider. A link's class is picked by priority. A link with no busy cycle at all is idle, whatever its buffer did. Next comes a buffer count above the congestion threshold, which means over-utilized. Next comes a busy count at or below the minimum-load threshold, which means under-utilized. Anything else is normal.

Top module: `link_util_classifier`

The sequencer has three states. `ST_IDLE` waits for `run`. `ST_COLLECT` counts for the latched window length. `ST_PUBLISH` is the single cycle in which the new codes and the valid strobe appear. The transitions are:
- IDLE→COLLECT when `run` is high.
- COLLECT→COLLECT until the last window cycle.
- COLLECT→PUBLISH on the last window cycle.
- PUBLISH→COLLECT when `run` is high.
- PUBLISH→IDLE when `run` is low.

## Requirements
- R1: After reset, `class_valid` is 0 and every link code reads 3 (idle).
- R2: A window spans exactly `win_len` counted cycles, with 0 taken as 1. The length is captured when the window starts, so changing `win_len` during a window has no effect on that window.
- R3: `class_valid` is high for exactly one cycle, in the cycle right after the last counted cycle of a window.
- R4: A link whose busy count for the window is zero gets code 3, whatever its buffer count is.
- R5: A link with a nonzero busy count and a buffer count strictly greater than `bcon_thr` gets code 0. This holds even when its busy count is at or below `lmin_thr`.
- R6: A link with a busy count between 1 and `lmin_thr` inclusive, and a buffer count at most `bcon_thr`, gets code 2.
- R7: A link with a busy count above `lmin_thr` and a buffer count at most `bcon_thr` gets code 1.
- R8: `class_code` changes only together with `class_valid`. Between strobes it holds the classes of the last completed window.
- R9: `run` is looked at only when leaving IDLE or PUBLISH. A window that has started always completes. With `run` low after PUBLISH, the block stays idle and gives no strobe.
- R10: Activity on `link_busy` and `buf_high` during IDLE and PUBLISH cycles is not counted.
- R11: Link i's code sits at `class_code[2i+1:2i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Keep measuring windows back to back |
| win_len | input | CNT_W | Window length in cycles (0 acts as 1) |
| lmin_thr | input | CNT_W | Minimum-load threshold, in busy cycles |
| bcon_thr | input | CNT_W | Congestion threshold, in buffer-high cycles |
| link_busy | input | NUM_LINKS | Per-link flit-carried flag for this cycle |
| buf_high | input | NUM_LINKS | Per-link buffer-occupancy-high flag for this cycle |
| class_code | output | 2*NUM_LINKS | Per-link class: 0 over, 1 normal, 2 under, 3 idle |
| class_valid | output | 1 | One-cycle strobe marking newly published codes |

## Verification
The final collect cycle does two things at the same clock edge: it increments the counters and it classifies the result. A link that is busy in every cycle of the window, the last one included, must reach the full count, so the bench compares a fully busy link against a threshold that the count misses by one cycle. The publish cycle is also where the next window's counters are cleared and where `run` is sampled. The bench drives every busy and buffer flag high during that cycle and checks that the following window still reports all links idle. It also drops `run` exactly in the publish cycle and checks that the strobe stops and the codes stay frozen.

// File: rtl/luc_pkg.sv
package luc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_PUBLISH = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        CLS_OVER   = 2'd0,
        CLS_NORMAL = 2'd1,
        CLS_UNDER  = 2'd2,
        CLS_IDLE   = 2'd3
    } util_class_e;

endpackage

// File: rtl/luc_window_seq.sv
module luc_window_seq
    import luc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] win_len,
    output seq_state_e       state_o,
    output logic             count_en,
    output logic             win_last,
    output logic [CNT_W-1:0] win_len_q
);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cyc_q;
    logic [CNT_W-1:0] len_eff;
    logic             starting;

    assign len_eff  = (win_len == '0) ? CNT_W'(1) : win_len;
    assign win_last = (state_q == ST_COLLECT) && (cyc_q == win_len_q - CNT_W'(1));
    assign starting = (state_q != ST_COLLECT) && (state_d == ST_COLLECT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (run) state_d = ST_COLLECT;
            ST_COLLECT: if (win_last) state_d = ST_PUBLISH;
            ST_PUBLISH: state_d = run ? ST_COLLECT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q     <= '0;
            win_len_q <= CNT_W'(1);
        end else begin
            if (starting) win_len_q <= len_eff;
            if (state_q == ST_COLLECT && !win_last) cyc_q <= cyc_q + CNT_W'(1);
            else                                    cyc_q <= '0;
        end
    end

    assign state_o  = state_q;
    assign count_en = (state_q == ST_COLLECT);

endmodule

// File: rtl/luc_link_counter.sv
module luc_link_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             busy_in,
    input  logic             bufh_in,
    output logic [CNT_W-1:0] busy_cnt,
    output logic [CNT_W-1:0] bufh_cnt,
    output logic [CNT_W-1:0] busy_nxt,
    output logic [CNT_W-1:0] bufh_nxt
);

    localparam logic [CNT_W-1:0] SAT = '1;

    always_comb begin
        busy_nxt = busy_cnt;
        bufh_nxt = bufh_cnt;
        if (count_en && busy_in && busy_cnt != SAT) busy_nxt = busy_cnt + CNT_W'(1);
        if (count_en && bufh_in && bufh_cnt != SAT) bufh_nxt = bufh_cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !count_en) begin
            busy_cnt <= '0;
            bufh_cnt <= '0;
        end else begin
            busy_cnt <= busy_nxt;
            bufh_cnt <= bufh_nxt;
        end
    end

endmodule

// File: rtl/luc_classify.sv
module luc_classify
    import luc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] busy_cnt,
    input  logic [CNT_W-1:0] bufh_cnt,
    input  logic [CNT_W-1:0] lmin_thr,
    input  logic [CNT_W-1:0] bcon_thr,
    output util_class_e      cls
);

    always_comb begin
        if (busy_cnt == '0)            cls = CLS_IDLE;
        else if (bufh_cnt > bcon_thr)  cls = CLS_OVER;
        else if (busy_cnt <= lmin_thr) cls = CLS_UNDER;
        else                           cls = CLS_NORMAL;
    end

endmodule

// File: rtl/link_util_classifier.sv
module link_util_classifier
    import luc_pkg::*;
#(
    parameter int NUM_LINKS = 4,
    parameter int CNT_W     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic [CNT_W-1:0]       win_len,
    input  logic [CNT_W-1:0]       lmin_thr,
    input  logic [CNT_W-1:0]       bcon_thr,
    input  logic [NUM_LINKS-1:0]   link_busy,
    input  logic [NUM_LINKS-1:0]   buf_high,
    output logic [2*NUM_LINKS-1:0] class_code,
    output logic                   class_valid
);

    localparam int CODE_W = 2 * NUM_LINKS;

    seq_state_e             seq_state;
    logic                   count_en;
    logic                   win_last;
    logic [CNT_W-1:0]       win_len_q;
    logic [NUM_LINKS*CNT_W-1:0] busy_cnt_flat;
    logic [CODE_W-1:0]      code_d;

    luc_window_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .win_len  (win_len),
        .state_o  (seq_state),
        .count_en (count_en),
        .win_last (win_last),
        .win_len_q(win_len_q)
    );

    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
        logic [CNT_W-1:0] busy_cnt, bufh_cnt, busy_nxt, bufh_nxt;
        util_class_e      cls;

        luc_link_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .count_en (count_en),
            .busy_in  (link_busy[i]),
            .bufh_in  (buf_high[i]),
            .busy_cnt (busy_cnt),
            .bufh_cnt (bufh_cnt),
            .busy_nxt (busy_nxt),
            .bufh_nxt (bufh_nxt)
        );

        luc_classify #(.CNT_W(CNT_W)) u_cls (
            .busy_cnt (busy_nxt),
            .bufh_cnt (bufh_nxt),
            .lmin_thr (lmin_thr),
            .bcon_thr (bcon_thr),
            .cls      (cls)
        );

        assign code_d[2*i +: 2]               = cls;
        assign busy_cnt_flat[i*CNT_W +: CNT_W] = busy_cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            class_valid <= 1'b0;
            class_code  <= '1;
        end else begin
            class_valid <= win_last;
            if (win_last) class_code <= code_d;
        end
    end

endmodule

// File: rtl/luc_checker.sv
module luc_checker
    import luc_pkg::*;
#(
    parameter int NUM_LINKS = 4,
    parameter int CNT_W     = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       run,
    input logic                       class_valid,
    input logic [2*NUM_LINKS-1:0]     class_code,
    input seq_state_e                 seq_state,
    input logic [CNT_W-1:0]           win_len_q,
    input logic [NUM_LINKS*CNT_W-1:0] busy_cnt_flat
);

    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        class_valid |=> !class_valid);

    p_valid_in_publish_r3: assert property (@(posedge clk) disable iff (!rst_n)
        class_valid |-> seq_state == ST_PUBLISH);

    p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !class_valid |-> $stable(class_code));

    p_no_count_outside_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != ST_COLLECT) |=> busy_cnt_flat == '0);

    p_stop_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_PUBLISH && !run) |=> seq_state == ST_IDLE);

    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_bound
        p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
            busy_cnt_flat[i*CNT_W +: CNT_W] <= win_len_q);
    end

endmodule

bind link_util_classifier luc_checker #(.NUM_LINKS(NUM_LINKS), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run),
    .class_valid  (class_valid),
    .class_code   (class_code),
    .seq_state    (seq_state),
    .win_len_q    (win_len_q),
    .busy_cnt_flat(busy_cnt_flat)
);

// File: tb/sim_link_util_classifier.sv
module sim_link_util_classifier;

    localparam int N = 4;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           run;
    logic [W-1:0]   win_len, lmin_thr, bcon_thr;
    logic [N-1:0]   link_busy, buf_high;
    logic [2*N-1:0] class_code;
    logic           class_valid;

    int errors = 0;
    int checks = 0;
    logic [2*N-1:0] prev_code;
    logic [N-1:0][W-1:0] pb, pf;

    always #2 clk = ~clk;

    link_util_classifier #(.NUM_LINKS(N), .CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .win_len(win_len),
        .lmin_thr(lmin_thr), .bcon_thr(bcon_thr),
        .link_busy(link_busy), .buf_high(buf_high),
        .class_code(class_code), .class_valid(class_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_code(input logic [W-1:0] b, input logic [W-1:0] f,
                                            input logic [W-1:0] lmin, input logic [W-1:0] bcon);
        if (b == 0)         return 2'd3;
        else if (f > bcon)  return 2'd0;
        else if (b <= lmin) return 2'd2;
        else                return 2'd1;
    endfunction

    // Entered at a negedge; runs one window and checks its publish cycle.
    task automatic do_window(input int len, input string tag);
        int eff;
        logic [2*N-1:0] e;
        eff = (len == 0) ? 1 : len;
        win_len = W'(len);
        @(posedge clk);
        for (int c = 0; c < eff; c++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                link_busy[i] = (c < pb[i]);
                buf_high[i]  = (c < pf[i]);
            end
            if (c == 0) begin
                win_len = W'(len + 7);  // R2: change mid-window must not matter
                check({tag, " R3 strobe low in window"}, 32'(class_valid), 32'd0);
                check({tag, " R8 codes held"}, 32'(class_code), 32'(prev_code));
            end
            @(posedge clk);
        end
        @(negedge clk);
        link_busy = '0;
        buf_high  = '0;
        for (int i = 0; i < N; i++) e[2*i +: 2] = exp_code(pb[i], pf[i], lmin_thr, bcon_thr);
        check({tag, " R2/R3 strobe at window end"}, 32'(class_valid), 32'd1);
        for (int i = 0; i < N; i++)
            check($sformatf("%s R4-R7 R11 link%0d code", tag, i),
                  32'(class_code[2*i +: 2]), 32'(e[2*i +: 2]));
        prev_code = e;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 valid after reset", 32'(class_valid), 32'd0);
        check("R1 codes after reset", 32'(class_code), 32'hFF);
        prev_code = 8'hFF;
    endtask

    task automatic t_basic();
        lmin_thr = 3; bcon_thr = 5;
        pb[0] = 0; pf[0] = 0;    // R4 idle
        pb[1] = 3; pf[1] = 0;    // R6 at lmin exactly
        pb[2] = 4; pf[2] = 5;    // R7 buffer equal to bcon
        pb[3] = 10; pf[3] = 6;   // R5 full window busy incl. last cycle
        run = 1'b1;
        do_window(10, "basic");
    endtask

    task automatic t_priority();
        pb[0] = 0;  pf[0] = 10;  // R4 beats over
        pb[1] = 1;  pf[1] = 9;   // R5 beats under
        pb[2] = 10; pf[2] = 0;   // R7
        pb[3] = 4;  pf[3] = 0;   // R7 just above lmin
        do_window(10, "priority");
    endtask

    task automatic t_publish_ignored();
        link_busy = '1;          // R10: during publish cycle
        buf_high  = '1;
        pb = '0; pf = '0;
        do_window(5, "publish_ignored_R10");
    endtask

    task automatic t_zero_thr();
        lmin_thr = 0; bcon_thr = 0;
        pb[0] = 8; pf[0] = 0;
        pb[1] = 1; pf[1] = 1;
        pb[2] = 2; pf[2] = 0;
        pb[3] = 0; pf[3] = 8;
        do_window(8, "zero_thr");
    endtask

    task automatic t_len_zero();
        lmin_thr = 3; bcon_thr = 0;
        pb[0] = 1; pf[0] = 0;
        pb[1] = 0; pf[1] = 0;
        pb[2] = 1; pf[2] = 1;
        pb[3] = 1; pf[3] = 0;
        do_window(0, "len_zero_R2");
    endtask

    task automatic t_stop_restart();
        run = 1'b0;              // dropped in publish cycle
        link_busy = '1;
        buf_high  = '1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check("R9 no strobe when stopped", 32'(class_valid), 32'd0);
            check("R8 codes frozen when stopped", 32'(class_code), 32'(prev_code));
        end
        run = 1'b1;
        pb = '0; pf = '0;
        do_window(4, "restart_R10");
        run = 1'b0;
        @(negedge clk);
        check("R3 strobe one cycle", 32'(class_valid), 32'd0);
    endtask

    initial begin
        #(4 * 20000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; run = 1'b0; win_len = 10; lmin_thr = 3; bcon_thr = 5;
        link_busy = '0; buf_high = '0; pb = '0; pf = '0; prev_code = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_priority();
        t_publish_ignored();
        t_zero_thr();
        t_len_zero();
        t_stop_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule